// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Logic

This block decides where each ALU operand of a five-stage in-order pipeline comes from, and when the front of the pipeline has to hold for one cycle. For the instruction now in execute, it compares both source register indices with the destination of the instruction one stage ahead (execute/memory boundary) and two stages ahead (memory/writeback boundary). It returns a 2-bit select for each operand mux. The pipeline registers and the muxes are not part of this block.

A second path covers the load-use case. It watches the instruction in execute and the instruction in decode. When the instruction in execute is a load and its destination is a source of the instruction in decode, the block raises a stall. The load result then reaches the bypass network one cycle later. Register zero is never treated as a dependency. All outputs are combinational and the block keeps no state.

Select encoding: 2'b00 takes the register file value, 2'b01 takes the execute/memory result, and 2'b10 takes the memory/writeback result. Code 2'b11 selects a constant zero on the mux input, and this block never produces it.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b01 when its source index is nonzero, equals `exmem_rd`, and `exmem_wen` is 1.
- R2: When R1 does not hold, an operand select is 2'b10 when its source index is nonzero, equals `memwb_rd`, and `memwb_wen` is 1.
- R3: When both the execute/memory and memory/writeback destinations match the same source and both write enables are set, the select is 2'b01, because the younger result wins.
- R4: A source index of zero always gives select 2'b00, even when a destination of zero is being written.
- R5: When there is no matching writer, the select is 2'b00, and the code 2'b11 never appears.
- R6: `fwd_b` follows R1 to R5 using `ex_rs2`, independently of `fwd_a` and `ex_rs1`.
- R7: `stall` is 1 when `idex_mem_rd` is 1, `idex_rd` is nonzero, and `idex_rd` equals `id_rs1` or `id_rs2`.
- R8: `stall` is 0 when `idex_mem_rd` is 0, when `idex_rd` is zero, or when neither decode source matches.
- R9: All outputs follow their inputs within the same time step, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source index of the instruction in execute |
| ex_rs2 | input | 5 | Second source index of the instruction in execute |
| exmem_rd | input | 5 | Destination index at the execute/memory boundary |
| exmem_wen | input | 1 | Register write enable at the execute/memory boundary |
| memwb_rd | input | 5 | Destination index at the memory/writeback boundary |
| memwb_wen | input | 1 | Register write enable at the memory/writeback boundary |
| id_rs1 | input | 5 | First source index of the instruction in decode |
| id_rs2 | input | 5 | Second source index of the instruction in decode |
| idex_rd | input | 5 | Destination index of the instruction in execute |
| idex_mem_rd | input | 1 | Instruction in execute reads memory |
| fwd_a | output | 2 | Select for the first ALU operand |
| fwd_b | output | 2 | Select for the second ALU operand |
| stall | output | 1 | Hold fetch and decode for one cycle |

## Verification
Random vectors draw the register indices from a small range. This makes matches against one writer, against both writers, and against register zero occur often, so the priority between the two stages and the zero exclusion are both exercised many times.

Directed cases cover the following:
- both writers matching one source, which separates the younger-wins rule from the opposite order;
- a write enable cleared while the index still matches, which shows that a bare index compare is not enough;
- a zero destination written by a load, which isolates the stall's zero check;
- opposite sources matching different writers, which shows that the two operands are independent.

A final input change with no clock edge confirms that the outputs are combinational.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int unsigned REG_IDX_W = 5;

  typedef enum logic [1:0] {
    SEL_RF     = 2'b00,
    SEL_EXMEM  = 2'b01,
    SEL_MEMWB  = 2'b10,
    SEL_ZERO   = 2'b11
  } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
#(
  parameter int unsigned IDX_W = REG_IDX_W
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] young_rd,
  input  logic             young_wen,
  input  logic [IDX_W-1:0] old_rd,
  input  logic             old_wen,
  output fwd_sel_e         sel
);
  logic src_live;
  logic hit_young;
  logic hit_old;

  always_comb begin
    src_live  = (src_idx != '0);
    hit_young = src_live && young_wen && (src_idx == young_rd);
    hit_old   = src_live && old_wen && (src_idx == old_rd);
    if (hit_young)    sel = SEL_EXMEM;
    else if (hit_old) sel = SEL_MEMWB;
    else              sel = SEL_RF;
  end

  always_comb begin
    a_r4_zero_src: assert ((src_idx != '0) || (sel == SEL_RF))
      else $error("zero source forwarded");
    a_r5_no_code3: assert (sel != SEL_ZERO)
      else $error("select 11 produced");
    a_r3_young_wins: assert (!(young_wen && src_idx == young_rd && src_idx != '0)
                             || sel == SEL_EXMEM)
      else $error("younger writer lost priority");
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
  import hazard_pkg::*;
#(
  parameter int unsigned IDX_W   = REG_IDX_W,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src,
  input  logic [IDX_W-1:0]              load_rd,
  input  logic                          load_vld,
  output logic                          hold
);
  logic [NUM_SRC-1:0] src_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign src_hit[g] = (dec_src[g] == load_rd);
  end

  assign hold = load_vld && (load_rd != '0) && (|src_hit);

  always_comb begin
    a_r8_no_zero_stall: assert (!hold || (load_vld && load_rd != '0))
      else $error("stall without a live load destination");
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int unsigned IDX_W = REG_IDX_W
) (
  input  logic [IDX_W-1:0] ex_rs1,
  input  logic [IDX_W-1:0] ex_rs2,
  input  logic [IDX_W-1:0] exmem_rd,
  input  logic             exmem_wen,
  input  logic [IDX_W-1:0] memwb_rd,
  input  logic             memwb_wen,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic [IDX_W-1:0] idex_rd,
  input  logic             idex_mem_rd,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall
);
  localparam int unsigned NUM_OPS = 2;

  logic [NUM_OPS-1:0][IDX_W-1:0] ex_src;
  fwd_sel_e                      op_sel [NUM_OPS];
  logic [NUM_OPS-1:0][IDX_W-1:0] dec_src;

  assign ex_src  = {ex_rs2, ex_rs1};
  assign dec_src = {id_rs2, id_rs1};

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_select #(.IDX_W(IDX_W)) u_sel (
      .src_idx  (ex_src[g]),
      .young_rd (exmem_rd),
      .young_wen(exmem_wen),
      .old_rd   (memwb_rd),
      .old_wen  (memwb_wen),
      .sel      (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  load_use_detect #(.IDX_W(IDX_W), .NUM_SRC(NUM_OPS)) u_lu (
    .dec_src (dec_src),
    .load_rd (idex_rd),
    .load_vld(idex_mem_rd),
    .hold    (stall)
  );

  always_comb begin
    a_r6_b_rule: assert ((fwd_b != 2'b10) || (memwb_wen && ex_rs2 == memwb_rd && ex_rs2 != '0))
      else $error("operand B took writeback result without a match");
    a_r7_stall_match: assert (!stall || idex_rd == id_rs1 || idex_rd == id_rs2)
      else $error("stall without a source match");
  end
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] ex_rs1, ex_rs2, exmem_rd, memwb_rd, id_rs1, id_rs2, idex_rd;
  logic       exmem_wen, memwb_wen, idex_mem_rd;
  logic [1:0] fwd_a, fwd_b;
  logic       stall;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  hazard_unit dut (
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
    .memwb_rd(memwb_rd), .memwb_wen(memwb_wen), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .idex_rd(idex_rd), .idex_mem_rd(idex_mem_rd),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall)
  );

  function automatic logic [1:0] ref_sel(input logic [4:0] rs);
    if (rs != 0 && exmem_wen && rs == exmem_rd) return 2'b01;
    if (rs != 0 && memwb_wen && rs == memwb_rd) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [4:0] rs);
    bit y = exmem_wen && rs == exmem_rd;
    bit o = memwb_wen && rs == memwb_rd;
    if (rs == 0) return "R4";
    if (y && o)  return "R3";
    if (y)       return "R1";
    if (o)       return "R2";
    return "R5";
  endfunction

  function automatic logic ref_stall();
    return idex_mem_rd && idex_rd != 0 && (idex_rd == id_rs1 || idex_rd == id_rs2);
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk(sel_tag(ex_rs1), fwd_a, ref_sel(ex_rs1));
    chk({"R6/", sel_tag(ex_rs2)}, fwd_b, ref_sel(ex_rs2));
    chk(ref_stall() ? "R7" : "R8", {1'b0, stall}, {1'b0, ref_stall()});
  endtask

  task automatic drive(input logic [4:0] a1, a2, yr, input logic yw,
                       input logic [4:0] orr, input logic ow,
                       input logic [4:0] d1, d2, lr, input logic lm);
    @(negedge clk);
    ex_rs1 = a1; ex_rs2 = a2; exmem_rd = yr; exmem_wen = yw;
    memwb_rd = orr; memwb_wen = ow; id_rs1 = d1; id_rs2 = d2;
    idex_rd = lr; idex_mem_rd = lm;
    #1 check_all();
  endtask

  initial begin
    ex_rs1 = 0; ex_rs2 = 0; exmem_rd = 0; exmem_wen = 0; memwb_rd = 0;
    memwb_wen = 0; id_rs1 = 0; id_rs2 = 0; idex_rd = 0; idex_mem_rd = 0;
    #1;
    // idle state: R5, R8
    chk("R5 idle", fwd_a, 2'b00);
    chk("R8 idle", {1'b0, stall}, 2'b00);
    // R1: match young
    drive(5'd3, 5'd9, 5'd3, 1, 5'd7, 1, 5'd1, 5'd2, 5'd4, 0);
    chk("R1 direct", fwd_a, 2'b01);
    // R2: match old
    drive(5'd7, 5'd9, 5'd3, 1, 5'd7, 1, 5'd1, 5'd2, 5'd4, 0);
    chk("R2 direct", fwd_a, 2'b10);
    // R3: both match, younger wins
    drive(5'd6, 5'd6, 5'd6, 1, 5'd6, 1, 5'd1, 5'd2, 5'd4, 0);
    chk("R3 direct", fwd_a, 2'b01);
    // R5: index matches but wen low
    drive(5'd6, 5'd6, 5'd6, 0, 5'd6, 0, 5'd1, 5'd2, 5'd4, 0);
    chk("R5 wen low", fwd_b, 2'b00);
    // R4: zero source, zero dest written
    drive(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, 5'd0, 5'd0, 5'd0, 1);
    chk("R4 zero", fwd_a, 2'b00);
    chk("R8 zero load dest", {1'b0, stall}, 2'b00);
    // R6: cross independence
    drive(5'd5, 5'd8, 5'd8, 1, 5'd5, 1, 5'd1, 5'd2, 5'd4, 0);
    chk("R6 a old", fwd_a, 2'b10);
    chk("R6 b young", fwd_b, 2'b01);
    // R7: stall on rs2 match
    drive(5'd0, 5'd0, 5'd0, 0, 5'd0, 0, 5'd1, 5'd12, 5'd12, 1);
    chk("R7 rs2", {1'b0, stall}, 2'b01);
    // R8: no memread
    drive(5'd0, 5'd0, 5'd0, 0, 5'd0, 0, 5'd12, 5'd12, 5'd12, 0);
    chk("R8 no load", {1'b0, stall}, 2'b00);
    // R9: change input without clock edge, outputs follow at once
    @(posedge clk); #1;
    ex_rs1 = 5'd12; exmem_rd = 5'd12; exmem_wen = 1; id_rs1 = 5'd12; idex_mem_rd = 1;
    #0.5;
    chk("R9 comb fwd", fwd_a, 2'b01);
    chk("R9 comb stall", {1'b0, stall}, 2'b01);
    // random
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 400; i++) begin
      drive($urandom % 4, $urandom % 4, $urandom % 4, 1'($urandom), $urandom % 4, 1'($urandom),
            $urandom % 4, $urandom % 4, $urandom % 4, 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule